// File: doc/BRIEF.md
# Dual-Channel Shadowed Configuration Register Bank

This block holds the control settings of a two-channel data converter behind a byte-wide register port (address, write data, write strobe, read strobe, registered read data). Some settings are shared by both channels, while the power settings exist once per channel. A channel-select register decides which channel copies a per-channel write lands in. The serial front end that turns a host bus into this port sits outside the block.

The power, stabilizer and clock-divide settings are double-buffered. Writes land in a master copy, which reads back at once. The outputs follow an active copy, which loads from the master only when software issues a commit command. A small controller sequences the commit and the self-clearing soft reset. From `ST_IDLE` it moves to `ST_COMMIT` on a commit write or to `ST_SRST` on a soft-reset write. `ST_COMMIT` follows the same exits as `ST_IDLE`. `ST_SRST` always returns to `ST_IDLE`. During `ST_SRST` the block drives its reset pulse and ignores all writes.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset, reads return 0x18 at 0x00, 0x03 at 0x05, 0x00 at 0x08, 0x01 at 0x09 and 0x00 at 0x0B. After reset the outputs are: all power modes 00, pin functions 0, `lsb_first` 0, divide field 0, `dcs_en` 1 and `soft_rst_pulse` 0.
- R2: Address 0x01 always reads the `CHIP_ID` parameter (default 0x3B), and writes to it change nothing.
- R3: Address 0x02 reads `{0, SPEED_GRADE[2:0], 0000}` (default grade 001, read 0x10), and writes to it change nothing.
- R4: A write to 0x00 sets `lsb_first` to the OR of data bits 6 and 1, and `lsb_first` changes after that clock edge without any commit. Both bits read back equal to it, and bits 4 and 3 always read 1.
- R5: A write to 0x08 updates the master of each channel whose bit in the index register 0x05 is set (bit 0 is channel A, bit 1 is channel B). If no index bit is set, the write updates no channel.
- R6: Writes to 0x08, 0x09 and 0x0B change only the master copies. The outputs `ch_pwr_mode`, `ch_pin_stby`, `clk_div_ratio` and `dcs_en` stay unchanged until a commit.
- R7: A write of 0xFF with bit 0 set loads every active copy from its master. Outputs show the new values one clock after the write edge. 0xFF always reads 0x00.
- R8: `clk_div_ratio` shows the active 0x0B bits [2:0], where the divide is the field value plus one. `dcs_en` is the active 0x09 bit 0 OR-ed with a nonzero active divide field.
- R9: A write to 0x00 with bit 5 or bit 2 set raises `soft_rst_pulse` for exactly one cycle. At the end of that cycle every register, master and active, holds its R1 value, and the reset bits read 0.
- R10: Writes to unlisted addresses have no effect, and reads of them return 0x00. Open bits read 0: at 0x08 only bits 5 and [1:0] are kept, and at 0x0B only bits [2:0] are kept.
- R11: A read of 0x08 returns the master of the lowest-numbered channel whose index bit is set, or channel A when no bit is set. The byte is laid out as bit 5 for the pin function and [1:0] for the mode.
- R12: `rdata` loads on a clock edge where `rd_en` is high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| ch_pwr_mode | output | 2*NUM_CH | Active power mode per channel, channel A in [1:0]; 00/11 normal, 01 off, 10 standby |
| ch_pin_stby | output | NUM_CH | Active external-pin function per channel, 1 = standby, 0 = power-down |
| lsb_first | output | 1 | Shift-order flag |
| clk_div_ratio | output | 3 | Active clock-divide field |
| dcs_en | output | 1 | Effective duty-cycle stabilizer enable |
| soft_rst_pulse | output | 1 | One-cycle soft reset indication |

## Verification
The hardest state to reach is one where the two channel masters hold different values and the active copies still hold older values. Reaching it takes index changes, per-channel writes and a delayed commit, in that order. The bench selects channel B alone, writes it, and reselects channel A to show that A's master did not change. It then commits and checks that both channel fields reach the outputs in the same cycle. The soft reset is issued over a state in which `lsb_first` and the masters are non-default, so that clearing them is visible.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
    localparam logic [7:0] A_PORTCFG = 8'h00;
    localparam logic [7:0] A_CHIPID  = 8'h01;
    localparam logic [7:0] A_GRADE   = 8'h02;
    localparam logic [7:0] A_INDEX   = 8'h05;
    localparam logic [7:0] A_PWR     = 8'h08;
    localparam logic [7:0] A_DCS     = 8'h09;
    localparam logic [7:0] A_CLKDIV  = 8'h0B;
    localparam logic [7:0] A_XFER    = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SRST   = 2'd2
    } ctl_state_t;

    typedef struct packed {
        logic       pin_stby;
        logic [1:0] mode;
    } chan_cfg_t;

    localparam chan_cfg_t CHAN_RST = '0;
endpackage

// File: rtl/cfg_ctrl_fsm.sv
module cfg_ctrl_fsm
    import cfg_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req,
    input  logic srst_req,
    output logic commit,
    output logic srst
);
    ctl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_COMMIT: begin
                if (srst_req)      state_d = ST_SRST;
                else if (xfer_req) state_d = ST_COMMIT;
                else               state_d = ST_IDLE;
            end
            ST_SRST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        srst   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: commit = 1'b1;
            ST_SRST:   srst   = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/cfg_chan_regs.sv
module cfg_chan_regs
    import cfg_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      srst,
    input  logic      wr,
    input  chan_cfg_t din,
    input  logic      commit,
    output chan_cfg_t master_q,
    output chan_cfg_t active_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= CHAN_RST;
            active_q <= CHAN_RST;
        end else if (srst) begin
            master_q <= CHAN_RST;
            active_q <= CHAN_RST;
        end else begin
            if (wr)     master_q <= din;
            if (commit) active_q <= master_q;
        end
    end
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              commit,
    input  logic              wr_portcfg,
    input  logic              wr_index,
    input  logic              wr_dcs,
    input  logic              wr_div,
    input  logic              lsb_in,
    input  logic [NUM_CH-1:0] idx_in,
    input  logic              dcs_in,
    input  logic [2:0]        div_in,
    output logic              lsb_first,
    output logic [NUM_CH-1:0] ch_idx,
    output logic              dcs_m,
    output logic [2:0]        div_m,
    output logic              dcs_a,
    output logic [2:0]        div_a
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lsb_first <= 1'b0;
            ch_idx    <= '1;
            dcs_m     <= 1'b1;
            div_m     <= '0;
            dcs_a     <= 1'b1;
            div_a     <= '0;
        end else if (srst) begin
            lsb_first <= 1'b0;
            ch_idx    <= '1;
            dcs_m     <= 1'b1;
            div_m     <= '0;
            dcs_a     <= 1'b1;
            div_a     <= '0;
        end else begin
            if (wr_portcfg) lsb_first <= lsb_in;
            if (wr_index)   ch_idx    <= idx_in;
            if (wr_dcs)     dcs_m     <= dcs_in;
            if (wr_div)     div_m     <= div_in;
            if (commit) begin
                dcs_a <= dcs_m;
                div_a <= div_m;
            end
        end
    end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import cfg_bank_pkg::*;
#(
    parameter int         NUM_CH      = 2,
    parameter logic [7:0] CHIP_ID     = 8'h3B,
    parameter logic [2:0] SPEED_GRADE = 3'b001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            addr,
    input  logic                  wr_en,
    input  logic [7:0]            wdata,
    input  logic                  rd_en,
    output logic [7:0]            rdata,
    output logic [2*NUM_CH-1:0]   ch_pwr_mode,
    output logic [NUM_CH-1:0]     ch_pin_stby,
    output logic                  lsb_first,
    output logic [2:0]            clk_div_ratio,
    output logic                  dcs_en,
    output logic                  soft_rst_pulse
);
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              commit, srst;
    logic              wr_ok, srst_req, xfer_req;
    logic [NUM_CH-1:0] ch_idx;
    logic              dcs_m, dcs_a;
    logic [2:0]        div_m, div_a;
    chan_cfg_t         ch_master [NUM_CH];
    chan_cfg_t         ch_active [NUM_CH];
    chan_cfg_t         ch_din;
    logic [2*NUM_CH-1:0] master_mode_vec;
    logic [SEL_W-1:0]  rd_sel;
    chan_cfg_t         rd_chan;
    logic [7:0]        rd_val;
    wire               unused_wbits = ^{wdata[7], wdata[4:3]};

    // Writes are dropped while the soft reset clears the bank.
    assign wr_ok    = wr_en && !srst;
    assign srst_req = wr_ok && (addr == A_PORTCFG) && (wdata[5] || wdata[2]);
    assign xfer_req = wr_ok && (addr == A_XFER) && wdata[0];
    assign ch_din   = '{pin_stby: wdata[5], mode: wdata[1:0]};

    cfg_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_req (xfer_req),
        .srst_req (srst_req),
        .commit   (commit),
        .srst     (srst)
    );

    cfg_global_regs #(.NUM_CH(NUM_CH)) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .commit     (commit),
        .wr_portcfg (wr_ok && addr == A_PORTCFG),
        .wr_index   (wr_ok && addr == A_INDEX),
        .wr_dcs     (wr_ok && addr == A_DCS),
        .wr_div     (wr_ok && addr == A_CLKDIV),
        .lsb_in     (wdata[6] | wdata[1]),
        .idx_in     (wdata[NUM_CH-1:0]),
        .dcs_in     (wdata[0]),
        .div_in     (wdata[2:0]),
        .lsb_first  (lsb_first),
        .ch_idx     (ch_idx),
        .dcs_m      (dcs_m),
        .div_m      (div_m),
        .dcs_a      (dcs_a),
        .div_a      (div_a)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        cfg_chan_regs u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .srst     (srst),
            .wr       (wr_ok && addr == A_PWR && ch_idx[g]),
            .din      (ch_din),
            .commit   (commit),
            .master_q (ch_master[g]),
            .active_q (ch_active[g])
        );
        assign ch_pwr_mode[2*g +: 2]     = ch_active[g].mode;
        assign ch_pin_stby[g]            = ch_active[g].pin_stby;
        assign master_mode_vec[2*g +: 2] = ch_master[g].mode;
    end

    assign clk_div_ratio  = div_a;
    assign dcs_en         = dcs_a | (|div_a);
    assign soft_rst_pulse = srst;

    // Local read picks the lowest selected channel, channel A if none.
    always_comb begin
        rd_sel = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ch_idx[i]) rd_sel = SEL_W'(i);
        end
    end
    assign rd_chan = ch_master[rd_sel];

    always_comb begin
        unique case (addr)
            A_PORTCFG: rd_val = {1'b0, lsb_first, 1'b0, 1'b1, 1'b1, 1'b0, lsb_first, 1'b0};
            A_CHIPID:  rd_val = CHIP_ID;
            A_GRADE:   rd_val = {1'b0, SPEED_GRADE, 4'b0000};
            A_INDEX:   rd_val = 8'(ch_idx);
            A_PWR:     rd_val = {2'b00, rd_chan.pin_stby, 3'b000, rd_chan.mode};
            A_DCS:     rd_val = {7'b0, dcs_m};
            A_CLKDIV:  rd_val = {5'b0, div_m};
            default:   rd_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/cfg_bank_checker.sv
module cfg_bank_checker #(
    parameter int         NUM_CH  = 2,
    parameter logic [7:0] CHIP_ID = 8'h3B
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          addr,
    input logic                rd_en,
    input logic [7:0]          rdata,
    input logic [2*NUM_CH-1:0] ch_pwr_mode,
    input logic [2:0]          clk_div_ratio,
    input logic                dcs_en,
    input logic                soft_rst_pulse,
    input logic                commit,
    input logic [2*NUM_CH-1:0] master_mode_vec
);
    function automatic logic is_unsup(input logic [7:0] a);
        case (a)
            8'h00, 8'h01, 8'h02, 8'h05, 8'h08, 8'h09, 8'h0B, 8'hFF: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    assert_srst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> !soft_rst_pulse);

    assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> (ch_pwr_mode == '0 && clk_div_ratio == 3'd0 && dcs_en));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !soft_rst_pulse) |=>
            ($stable(ch_pwr_mode) && $stable(clk_div_ratio) && $stable(dcs_en)));

    assert_commit_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ch_pwr_mode == $past(master_mode_vec)));

    assert_chip_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h01) |=> (rdata == CHIP_ID));

    assert_unsup_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_unsup(addr)) |=> (rdata == 8'h00));
endmodule

bind cfg_shadow_bank cfg_bank_checker #(.NUM_CH(NUM_CH), .CHIP_ID(CHIP_ID)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr            (addr),
    .rd_en           (rd_en),
    .rdata           (rdata),
    .ch_pwr_mode     (ch_pwr_mode),
    .clk_div_ratio   (clk_div_ratio),
    .dcs_en          (dcs_en),
    .soft_rst_pulse  (soft_rst_pulse),
    .commit          (commit),
    .master_mode_vec (master_mode_vec)
);

// File: tb/cfg_shadow_bank_bench.sv
module cfg_shadow_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    typedef struct packed {
        logic       w;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] e;
        logic [3:0] r;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 8'h00, 8'h18, 4'd1},   // R1 port config reset
        '{1'b0, 8'h01, 8'h00, 8'h3B, 4'd2},   // R2 chip id
        '{1'b0, 8'h02, 8'h00, 8'h10, 4'd3},   // R3 grade
        '{1'b0, 8'h05, 8'h00, 8'h03, 4'd1},   // R1 index reset
        '{1'b0, 8'h09, 8'h00, 8'h01, 4'd1},   // R1 stabilizer reset
        '{1'b1, 8'h01, 8'hFF, 8'h00, 4'd2},   // R2 write ignored
        '{1'b0, 8'h01, 8'h00, 8'h3B, 4'd2},
        '{1'b1, 8'h02, 8'hFF, 8'h00, 4'd3},   // R3 write ignored
        '{1'b0, 8'h02, 8'h00, 8'h10, 4'd3},
        '{1'b1, 8'h00, 8'h02, 8'h00, 4'd4},   // R4 set via bit 1
        '{1'b0, 8'h00, 8'h00, 8'h5A, 4'd4},
        '{1'b1, 8'h00, 8'h00, 8'h00, 4'd4},
        '{1'b0, 8'h00, 8'h00, 8'h18, 4'd4},
        '{1'b1, 8'h0B, 8'hFD, 8'h00, 4'd10},  // R10 open bits of divide
        '{1'b0, 8'h0B, 8'h00, 8'h05, 4'd10},
        '{1'b1, 8'h08, 8'hFF, 8'h00, 4'd10},  // R10 open bits of power
        '{1'b0, 8'h08, 8'h00, 8'h23, 4'd10},
        '{1'b1, 8'h33, 8'hAA, 8'h00, 4'd10},  // R10 unlisted address
        '{1'b0, 8'h33, 8'h00, 8'h00, 4'd10},
        '{1'b1, 8'hFF, 8'h00, 8'h00, 4'd7},   // R7 zero write, no commit
        '{1'b0, 8'hFF, 8'h00, 8'h00, 4'd7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [3:0] ch_pwr_mode;
    logic [1:0] ch_pin_stby;
    logic       lsb_first;
    logic [2:0] clk_div_ratio;
    logic       dcs_en;
    logic       soft_rst_pulse;

    int  n_chk = 0;
    int  n_bad = 0;
    logic done = 1'b0;
    logic [7:0] got;

    cfg_shadow_bank u_cfg_shadow_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .addr           (addr),
        .wr_en          (wr_en),
        .wdata          (wdata),
        .rd_en          (rd_en),
        .rdata          (rdata),
        .ch_pwr_mode    (ch_pwr_mode),
        .ch_pin_stby    (ch_pin_stby),
        .lsb_first      (lsb_first),
        .clk_div_ratio  (clk_div_ratio),
        .dcs_en         (dcs_en),
        .soft_rst_pulse (soft_rst_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input int r, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wait_cycle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 output reset state
        chk(1, 8'(ch_pwr_mode), 8'h00);
        chk(1, 8'(ch_pin_stby), 8'h00);
        chk(1, {lsb_first, dcs_en, soft_rst_pulse, 2'b0, clk_div_ratio}, 8'h40);
        chk(12, rdata, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].w) wr(VECS[i].a, VECS[i].d);
            else begin
                rd(VECS[i].a, got);
                chk(int'(VECS[i].r), got, VECS[i].e);
            end
        end

        // R6: masters hold 0x23 and divide 5, outputs untouched
        chk(6, 8'(ch_pwr_mode), 8'h00);
        chk(6, {5'b0, clk_div_ratio}, 8'h00);

        // R7: commit, outputs move one clock after the write edge
        wr(8'hFF, 8'h01);
        chk(7, 8'(ch_pwr_mode), 8'h00);
        wait_cycle();
        chk(7, 8'(ch_pwr_mode), 8'h0F);
        chk(7, 8'(ch_pin_stby), 8'h03);
        chk(8, {4'b0, dcs_en, clk_div_ratio}, 8'h0D);
        rd(8'hFF, got);
        chk(7, got, 8'h00);

        // R5 / R11: steer to channel B only
        wr(8'h05, 8'h02);
        wr(8'h08, 8'h01);
        rd(8'h08, got);
        chk(11, got, 8'h01);
        wr(8'h05, 8'h01);
        rd(8'h08, got);
        chk(5, got, 8'h23);
        wr(8'hFF, 8'h01);
        wait_cycle();
        chk(5, 8'(ch_pwr_mode), 8'h07);
        chk(5, 8'(ch_pin_stby), 8'h01);

        // R8: stabilizer forced by nonzero divide
        wr(8'h0B, 8'h00);
        wr(8'h09, 8'h00);
        wr(8'hFF, 8'h01);
        wait_cycle();
        chk(8, {7'b0, dcs_en}, 8'h00);
        wr(8'h0B, 8'h03);
        chk(6, {7'b0, dcs_en}, 8'h00);
        wr(8'hFF, 8'h01);
        wait_cycle();
        chk(8, {4'b0, dcs_en, clk_div_ratio}, 8'h0B);

        // R11 both selected reads A; R5 no channel selected
        wr(8'h05, 8'h03);
        rd(8'h08, got);
        chk(11, got, 8'h23);
        wr(8'h05, 8'h00);
        wr(8'h08, 8'h02);
        rd(8'h08, got);
        chk(5, got, 8'h23);
        wr(8'h05, 8'h02);
        rd(8'h08, got);
        chk(5, got, 8'h01);

        // R12: read data holds without rd_en
        rd(8'h01, got);
        @(negedge clk);
        addr = 8'h05;
        @(negedge clk);
        chk(12, rdata, 8'h3B);

        // R9: soft reset over non-default state
        wr(8'h00, 8'h66);
        chk(9, {7'b0, soft_rst_pulse}, 8'h01);
        wait_cycle();
        chk(9, {7'b0, soft_rst_pulse}, 8'h00);
        chk(9, {lsb_first, dcs_en, 3'b0, clk_div_ratio}, 8'h40);
        chk(9, 8'(ch_pwr_mode), 8'h00);
        chk(9, 8'(ch_pin_stby), 8'h00);
        rd(8'h00, got); chk(9, got, 8'h18);
        rd(8'h05, got); chk(9, got, 8'h03);
        rd(8'h08, got); chk(9, got, 8'h00);
        rd(8'h0B, got); chk(9, got, 8'h00);
        rd(8'h09, got); chk(9, got, 8'h01);
        wr(8'h00, 8'h04);
        chk(9, {7'b0, soft_rst_pulse}, 8'h01);
        wait_cycle();
        chk(9, {7'b0, soft_rst_pulse}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule